// File: doc/BRIEF.md
# Dual-Address Latch Register File

A small storage array of four words, each four bits wide, with a write port and a read port that are decoded independently. The write side stores a word into level-sensitive latches: while the active-low write enable is low, the word chosen by the write address follows the data inputs, and it keeps its last value once the enable returns high. The read side is purely combinational. The read address picks a word, and that word appears on the output for as long as the active-low read enable is low.

When the read enable is high, the output floats to high impedance. Several files can therefore share one output bus to give more words, and files can sit side by side to give a wider word. Because the two ports are decoded separately, one word can be read while another is being written. Reading the word that is being written shows the incoming data at once, through the open latch. Contents are undefined at power-up until each word has been written.

Top module: `rfl_regfile`

## Requirements
- R1: The array holds 4 words of 4 bits; address value i selects word i on both ports, and each word keeps its own value independently of the others.
- R2: While `wr_en_n_i` is 0, the word selected by `wr_addr_i` takes the value on `wr_data_i` in true (non-inverted) form, and no other word changes.
- R3: While `wr_en_n_i` is 1, no change on `wr_addr_i` or `wr_data_i` alters any stored word.
- R4: The write is level-sensitive: while enabled, the addressed word tracks every change of `wr_data_i`, and it holds the value present when `wr_en_n_i` rises.
- R5: While `rd_en_n_i` is 0, `rd_q_o` equals the word selected by `rd_addr_i`, with no clock: a change of address shows on the output in the same cycle.
- R6: While `rd_en_n_i` is 1, all four bits of `rd_q_o` are released (high impedance), so another driver can own the bus.
- R7: Reading one word while a different word is being written returns the read word's stored value, unaffected by the write.
- R8: When the read and write addresses match during an active write, with reading enabled, `rd_q_o` equals `wr_data_i`.
- R9: Reading does not change stored data; repeated reads of a word return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_addr_i | input | 2 | Word selected for writing |
| wr_data_i | input | 4 | Data written into the selected word |
| wr_en_n_i | input | 1 | Write enable, active low, level-sensitive |
| rd_addr_i | input | 2 | Word selected for reading |
| rd_en_n_i | input | 1 | Read enable, active low; when high the output floats |
| rd_q_o | output | 4 | Read data, high impedance when reading is disabled |

## Verification
The hardest condition to observe from the ports is the released output: a floating bus cannot be read back as a value. To check it, the bench drives the shared bus itself with two complementary patterns while reading is disabled. It expects each pattern back unchanged, which can only happen if the block is not driving. The transparent write is also hard to reach. To test it, the bench opens a write to the word being read, changes the data several times inside one enable window, and checks that each new value appears at once. After the enable closes, it checks that the word kept the last value.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

    localparam int WORDS  = 4;
    localparam int WIDTH  = 4;
    localparam int ADDR_W = $clog2(WORDS);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WIDTH-1:0]  word_t;

    // Write request carried from the top into the decoder and latches.
    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_req_t;

    // Read request carried from the top into the selector.
    typedef struct packed {
        logic  en;
        addr_t addr;
    } rd_req_t;

    // One-hot strobe for the addressed word, all zero when not enabled.
    function automatic logic [WORDS-1:0] strobe_of(input addr_t a, input logic en);
        logic [WORDS-1:0] s;
        s = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (en && (a == addr_t'(i))) s[i] = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/rfl_wr_decode.sv
module rfl_wr_decode
    import rfl_pkg::*;
#(
    parameter int N_WORDS = rfl_pkg::WORDS
) (
    input  wr_req_t            req_i,
    output logic [N_WORDS-1:0] strobe_o
);

    always_comb begin
        strobe_o = strobe_of(req_i.addr, req_i.en)[N_WORDS-1:0];
    end

endmodule

// File: rtl/rfl_latch_word.sv
module rfl_latch_word #(
    parameter int W = rfl_pkg::WIDTH
) (
    input  logic         gate_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Transparent while the gate is open; holds otherwise.
    always_latch begin
        if (gate_i) q_o = d_i;
    end

endmodule

// File: rtl/rfl_rd_select.sv
module rfl_rd_select
    import rfl_pkg::*;
#(
    parameter int N_WORDS = rfl_pkg::WORDS,
    parameter int W       = rfl_pkg::WIDTH
) (
    input  logic [N_WORDS-1:0][W-1:0] words_i,
    input  rd_req_t                   req_i,
    output logic [W-1:0]              data_o,
    output logic                      drive_o
);

    always_comb begin
        data_o = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (req_i.addr == addr_t'(i)) data_o = words_i[i];
        end
        drive_o = req_i.en;
    end

endmodule

// File: rtl/rfl_regfile.sv
module rfl_regfile
    import rfl_pkg::*;
(
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    input  logic              wr_en_n_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_en_n_i,
    output logic [WIDTH-1:0]  rd_q_o
);

    wr_req_t                      wr_req;
    rd_req_t                      rd_req;
    logic [WORDS-1:0]             wr_strobe;
    logic [WORDS-1:0][WIDTH-1:0]  words;
    logic [WIDTH-1:0]             rd_data;
    logic                         drive_en;

    always_comb begin
        wr_req.en   = ~wr_en_n_i;
        wr_req.addr = wr_addr_i;
        wr_req.data = wr_data_i;
        rd_req.en   = ~rd_en_n_i;
        rd_req.addr = rd_addr_i;
    end

    rfl_wr_decode #(.N_WORDS(WORDS)) u_dec (
        .req_i    (wr_req),
        .strobe_o (wr_strobe)
    );

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        rfl_latch_word #(.W(WIDTH)) u_word (
            .gate_i (wr_strobe[g]),
            .d_i    (wr_req.data),
            .q_o    (words[g])
        );
    end

    rfl_rd_select #(.N_WORDS(WORDS), .W(WIDTH)) u_sel (
        .words_i (words),
        .req_i   (rd_req),
        .data_o  (rd_data),
        .drive_o (drive_en)
    );

    // Bus driver: released when reading is disabled.
    assign rd_q_o = drive_en ? rd_data : {WIDTH{1'bz}};

endmodule

// File: rtl/rfl_regfile_chk.sv
module rfl_regfile_chk
    import rfl_pkg::*;
(
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    input  logic              wr_en_n_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_en_n_i,
    input  logic [WORDS-1:0]  wr_strobe,
    input  logic [WIDTH-1:0]  rd_data
);

    always_comb begin
        // R1
        strobe_onehot_chk: assert ($onehot0(wr_strobe));
        if (!wr_en_n_i) begin
            // R2
            strobe_match_chk: assert (wr_strobe[wr_addr_i] && ($countones(wr_strobe) == 1));
        end else begin
            // R3
            strobe_idle_chk: assert (wr_strobe == '0);
        end
        if (!wr_en_n_i && !rd_en_n_i && (rd_addr_i == wr_addr_i)) begin
            // R8
            bypass_chk: assert (rd_data == wr_data_i);
        end
    end

endmodule

bind rfl_regfile rfl_regfile_chk u_chk (
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_en_n_i (wr_en_n_i),
    .rd_addr_i (rd_addr_i),
    .rd_en_n_i (rd_en_n_i),
    .wr_strobe (wr_strobe),
    .rd_data   (rd_data)
);

// File: tb/rfl_regfile_tb_top.sv
`timescale 1ns/100ps
module rfl_regfile_tb_top;

    logic       clk = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic       wr_en_n = 1'b1;
    logic [1:0] rd_addr = '0;
    logic       rd_en_n = 1'b1;
    logic       tb_drv_en = 1'b0;
    logic [3:0] tb_drv_val = '0;
    wire  [3:0] q_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rfl_regfile dut_i (
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .wr_en_n_i (wr_en_n),
        .rd_addr_i (rd_addr),
        .rd_en_n_i (rd_en_n),
        .rd_q_o    (q_bus)
    );

    // Second driver sharing the bus, used to prove the block has let go.
    assign q_bus = tb_drv_en ? tb_drv_val : 4'bzzzz;

    typedef struct packed {
        logic       we_n;
        logic [1:0] wa;
        logic [3:0] wd;
        logic       re_n;
        logic [1:0] ra;
        logic [3:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'hA, 1'b1, 2'd0, 4'h0}, // R6 write w0, bus released
        '{1'b0, 2'd1, 4'h5, 1'b0, 2'd0, 4'hA}, // R7 write w1, read w0
        '{1'b0, 2'd2, 4'hC, 1'b0, 2'd2, 4'hC}, // R8 same address
        '{1'b0, 2'd3, 4'h3, 1'b0, 2'd1, 4'h5}, // R7 write w3, read w1
        '{1'b1, 2'd0, 4'hF, 1'b0, 2'd0, 4'hA}, // R3 data ignored
        '{1'b1, 2'd3, 4'h0, 1'b0, 2'd3, 4'h3}, // R2 w3 stored
        '{1'b1, 2'd2, 4'h1, 1'b0, 2'd2, 4'hC}, // R2 w2 stored
        '{1'b1, 2'd1, 4'h9, 1'b0, 2'd0, 4'hA}, // R9 reread w0
        '{1'b1, 2'd0, 4'h0, 1'b1, 2'd0, 4'h0}, // R6 released
        '{1'b0, 2'd1, 4'h6, 1'b0, 2'd1, 4'h6}, // R8 overwrite w1
        '{1'b1, 2'd1, 4'hF, 1'b0, 2'd1, 4'h6}, // R3 w1 kept
        '{1'b1, 2'd0, 4'h0, 1'b0, 2'd1, 4'h6}  // R9 reread w1
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Released-bus check: two complementary patterns must come back unchanged.
    task automatic check_released(input string req);
        tb_drv_en = 1'b1; tb_drv_val = 4'b1010;
        #0.2 check(req, q_bus, 4'b1010);
        tb_drv_val = 4'b0101;
        #0.2 check(req, q_bus, 4'b0101);
        tb_drv_en = 1'b0;
    endtask

    task automatic read_word(input logic [1:0] a, input logic [3:0] exp, input string req);
        @(posedge clk); #1;
        wr_en_n = 1'b1; rd_en_n = 1'b0; rd_addr = a;
        #1 check(req, q_bus, exp);
    endtask

    task automatic write_word(input logic [1:0] a, input logic [3:0] d);
        @(posedge clk); #1;
        wr_en_n = 1'b1; wr_addr = a; wr_data = d;
        #1 wr_en_n = 1'b0;
        #1 wr_en_n = 1'b1;
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] img [4];
        // Power-up: bus released before any write (R6)
        repeat (2) @(posedge clk);
        #1 check_released("R6");

        // Fill all words with distinct values, read each back (R1, R5)
        for (int i = 0; i < 4; i++) begin
            img[i] = 4'(4'h9 + i * 3);
            write_word(2'(i), img[i]);
        end
        for (int i = 0; i < 4; i++) read_word(2'(i), img[i], "R1");
        // Address change shows in the same cycle (R5)
        @(posedge clk); #1 rd_en_n = 1'b0; rd_addr = 2'd3;
        #0.5 check("R5", q_bus, img[3]);
        rd_addr = 2'd1;
        #0.5 check("R5", q_bus, img[1]);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(posedge clk); #1;
            wr_en_n = 1'b1; wr_addr = VECS[v].wa; wr_data = VECS[v].wd;
            rd_en_n = VECS[v].re_n; rd_addr = VECS[v].ra;
            #1 wr_en_n = VECS[v].we_n;
            #1;
            if (VECS[v].re_n) check_released("R6");
            else check($sformatf("table row %0d", v), q_bus, VECS[v].exp);
            #0.5 wr_en_n = 1'b1;
        end
        img[0] = 4'hA; img[1] = 4'h6; img[2] = 4'hC; img[3] = 4'h3;

        // Transparent write tracking and hold on enable release (R4)
        @(posedge clk); #1;
        rd_en_n = 1'b0; rd_addr = 2'd2; wr_addr = 2'd2; wr_data = 4'h1;
        wr_en_n = 1'b0;
        #0.5 check("R4", q_bus, 4'h1);
        wr_data = 4'h2;
        #0.5 check("R4", q_bus, 4'h2);
        wr_data = 4'h7;
        #0.5 check("R4", q_bus, 4'h7);
        wr_en_n = 1'b1;
        #0.5 wr_data = 4'h0;
        #0.5 check("R4", q_bus, 4'h7);
        img[2] = 4'h7;

        // Disabled write: sweep addresses and data, nothing changes (R3)
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 16; d++) begin
                @(posedge clk); #1 wr_addr = 2'(a); wr_data = 4'(d);
            end
        end
        for (int i = 0; i < 4; i++) read_word(2'(i), img[i], "R3");

        // Repeated reads are stable (R9)
        for (int r = 0; r < 3; r++) read_word(2'd3, img[3], "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule